// File: doc/BRIEF.md
# Sixteen-Pin General-Purpose I/O Port with Atomic Bit Updates

This block is a general-purpose I/O port with sixteen pins behind a small register interface. Each pin can be an input or an output. The output data register can be written whole, or changed through separate set, clear and toggle addresses. In those three addresses a one changes the pin at that bit position and a zero leaves the pin alone, so one write can change any group of pins and no read-modify-write is needed.

Input pins pass through a two-stage synchronizer before software can read them and before edge detection sees them. Each pin can request an interrupt. The pin's configuration picks one of three trigger modes: level (active high, no latch), rising edge only, or both edges. An edge is held in a per-pin pending latch until software writes one to that pin's bit at the pending address. A pin configured as an output takes part in interrupt detection through the value it drives, so software can raise an interrupt by writing that pin's data bit. A mask bit for each pin decides whether its request reaches the single combined interrupt line.

The write port takes one register write per cycle when `bus_wr` is high. The read port is combinational from `bus_raddr`. Register addresses (4 bits): 0 direction, 1 data (direct write), 2 data set, 3 data clear, 4 data toggle, 5 interrupt mask, 6 edge select, 7 both-edge select, 8 pending latch (read) / pending clear (write-one), 9 pin level (read only). Addresses 2, 3 and 4 read as zero.

Top module: `gpio_port`

## Requirements
- R1: After reset the direction, data, mask, edge-select, both-edge and pending registers all read 0, `pin_oe` and `pin_out` are 0 and `irq` is low.
- R2: Writing the direction register (address 0) drives `pin_oe` with its value: a 1 makes that pin an output. `pin_out` always shows the data register.
- R3: Writing to the set address (2) makes the data register the old value OR the written word. Bits written as zero keep their level.
- R4: Writing to the clear address (3) makes the data register the old value AND the inverse of the written word.
- R5: Writing to the toggle address (4) makes the data register the old value XOR the written word.
- R6: Reading the pin address (9) returns, for each input pin, the level `pin_in` had two clock edges earlier. For each output pin it returns the driven data bit.
- R7: For a pin whose edge-select bit (address 6) is 0, the request is the pin's current level (active high) with no latch.
- R8: For a pin whose edge-select bit is 1, a rising edge sets the pin's pending bit (read at address 8). The bit stays set after the pin falls. It clears only when a write to address 8 has a one at that bit. Bits written as zero at address 8 leave their pending bit unchanged.
- R9: With the both-edge bit (address 7) at 1, an edge-mode pin also latches on a falling edge. With the bit at 0, a falling edge is ignored.
- R10: `irq` is the OR over all pins of the request ANDed with the mask bit (address 5). A masked pin still records its pending bit.
- R11: A pin configured as an output feeds its driven value into detection, so setting its data bit raises that pin's request.
- R12: Writing address 1 loads the data register with the whole written word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_waddr | input | 4 | Write register address |
| bus_wdata | input | 16 | Write data, one bit per pin |
| bus_raddr | input | 4 | Read register address |
| bus_rdata | output | 16 | Read data, combinational from bus_raddr |
| pin_in | input | 16 | Pad input levels, asynchronous |
| pin_out | output | 16 | Driven output levels |
| pin_oe | output | 16 | Output enable per pin |
| irq | output | 1 | Combined masked interrupt request |

## Verification
The hardest case to reach is a pending latch that must survive the pin dropping back, and must also ignore a clear word that misses its bit. Reaching it takes a rising edge, a return to the idle level, and then clear writes to the wrong bit and to the right bit. Each step is timed against the two synchronizer stages and the edge register. The stimulus walks one pin through exactly that order and samples the pending register after each step. It then repeats the walk with both-edge mode on, clearing the rising-edge latch before the fall so that only the falling edge can set it again. A software-raised interrupt is reached by first clearing an output pin's data bit, putting that pin into edge mode, and then setting the bit through the set address.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
    localparam int ADDR_W = 4;

    typedef enum logic [ADDR_W-1:0] {
        REG_DIR  = 4'd0,
        REG_DATA = 4'd1,
        REG_SET  = 4'd2,
        REG_CLR  = 4'd3,
        REG_TGL  = 4'd4,
        REG_MASK = 4'd5,
        REG_EDGE = 4'd6,
        REG_BOTH = 4'd7,
        REG_PEND = 4'd8,
        REG_PIN  = 4'd9
    } reg_addr_e;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int WIDTH  = 16,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    logic [WIDTH-1:0] chain [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    chain[s] <= '0;
                end else if (s == 0) begin
                    chain[s] <= async_in;
                end else begin
                    chain[s] <= chain[(s > 0) ? s-1 : 0];
                end
            end
        end
    endgenerate

    assign sync_out = chain[STAGES-1];
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
    import gpio_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [WIDTH-1:0]  wr_data,
    output logic [WIDTH-1:0]  dir,
    output logic [WIDTH-1:0]  data,
    output logic [WIDTH-1:0]  mask,
    output logic [WIDTH-1:0]  edge_sel,
    output logic [WIDTH-1:0]  both_sel,
    output logic [WIDTH-1:0]  pend_clr
);
    reg_addr_e waddr;
    assign waddr = reg_addr_e'(wr_addr);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dir      <= '0;
            data     <= '0;
            mask     <= '0;
            edge_sel <= '0;
            both_sel <= '0;
        end else if (wr_en) begin
            case (waddr)
                REG_DIR:  dir      <= wr_data;
                REG_DATA: data     <= wr_data;
                REG_SET:  data     <= data | wr_data;
                REG_CLR:  data     <= data & ~wr_data;
                REG_TGL:  data     <= data ^ wr_data;
                REG_MASK: mask     <= wr_data;
                REG_EDGE: edge_sel <= wr_data;
                REG_BOTH: both_sel <= wr_data;
                default:  ;
            endcase
        end
    end

    assign pend_clr = (wr_en && waddr == REG_PEND) ? wr_data : '0;

    a_r3_set_merges: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && waddr == REG_SET) |=> data == ($past(data) | $past(wr_data)));
    a_r4_clr_merges: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && waddr == REG_CLR) |=> data == ($past(data) & ~$past(wr_data)));
    a_r5_tgl_merges: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && waddr == REG_TGL) |=> data == ($past(data) ^ $past(wr_data)));
endmodule

// File: rtl/gpio_irq.sv
module gpio_irq #(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] view,
    input  logic [WIDTH-1:0] edge_sel,
    input  logic [WIDTH-1:0] both_sel,
    input  logic [WIDTH-1:0] mask,
    input  logic [WIDTH-1:0] pend_clr,
    output logic [WIDTH-1:0] pend,
    output logic             irq
);
    logic [WIDTH-1:0] prev;
    logic [WIDTH-1:0] rise;
    logic [WIDTH-1:0] fall;
    logic [WIDTH-1:0] hit;
    logic [WIDTH-1:0] req;

    assign rise = view & ~prev;
    assign fall = ~view & prev;
    assign hit  = edge_sel & (rise | (both_sel & fall));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev <= '0;
            pend <= '0;
        end else begin
            prev <= view;
            pend <= (pend & ~pend_clr) | hit;
        end
    end

    assign req = (edge_sel & pend) | (~edge_sel & view);
    assign irq = |(req & mask);

    a_r8_pend_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_clr == '0) |=> ((pend & $past(pend)) == $past(pend)));
    a_r8_pend_needs_edge_mode: assert property (@(posedge clk) disable iff (!rst_n)
        ((pend & ~$past(pend)) & ~$past(edge_sel)) == '0);
endmodule

// File: rtl/gpio_port.sv
module gpio_port
    import gpio_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_waddr,
    input  logic [WIDTH-1:0]  bus_wdata,
    input  logic [ADDR_W-1:0] bus_raddr,
    output logic [WIDTH-1:0]  bus_rdata,
    input  logic [WIDTH-1:0]  pin_in,
    output logic [WIDTH-1:0]  pin_out,
    output logic [WIDTH-1:0]  pin_oe,
    output logic              irq
);
    logic [WIDTH-1:0] dir, data, mask, edge_sel, both_sel, pend_clr;
    logic [WIDTH-1:0] sync_in, view, pend;

    gpio_sync #(.WIDTH(WIDTH), .STAGES(2)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (pin_in),
        .sync_out (sync_in)
    );

    gpio_regs #(.WIDTH(WIDTH)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (bus_wr),
        .wr_addr  (bus_waddr),
        .wr_data  (bus_wdata),
        .dir      (dir),
        .data     (data),
        .mask     (mask),
        .edge_sel (edge_sel),
        .both_sel (both_sel),
        .pend_clr (pend_clr)
    );

    assign view = (dir & data) | (~dir & sync_in);

    gpio_irq #(.WIDTH(WIDTH)) u_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .view     (view),
        .edge_sel (edge_sel),
        .both_sel (both_sel),
        .mask     (mask),
        .pend_clr (pend_clr),
        .pend     (pend),
        .irq      (irq)
    );

    assign pin_out = data;
    assign pin_oe  = dir;

    always_comb begin
        case (reg_addr_e'(bus_raddr))
            REG_DIR:  bus_rdata = dir;
            REG_DATA: bus_rdata = data;
            REG_MASK: bus_rdata = mask;
            REG_EDGE: bus_rdata = edge_sel;
            REG_BOTH: bus_rdata = both_sel;
            REG_PEND: bus_rdata = pend;
            REG_PIN:  bus_rdata = view;
            default:  bus_rdata = '0;
        endcase
    end

    a_r10_mask_gates_irq: assert property (@(posedge clk) disable iff (!rst_n)
        (mask == '0) |-> !irq);
    a_r1_quiet_after_reset: assert property (@(posedge clk)
        $rose(rst_n) |-> (pin_oe == '0 && !irq));
endmodule

// File: tb/test_gpio_port.sv
`timescale 1ns/1ps
module test_gpio_port;
    localparam int W = 16;

    typedef enum logic [1:0] {K_REG, K_IRQ, K_OE, K_OUT} kind_e;
    typedef struct {
        kind_e       kind;
        logic [3:0]  addr;
        logic [15:0] exp;
        string       req;
    } item_t;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_wr = 1'b0;
    logic [3:0]    bus_waddr = '0;
    logic [W-1:0]  bus_wdata = '0;
    logic [3:0]    bus_raddr = '0;
    logic [W-1:0]  bus_rdata;
    logic [W-1:0]  pin_in = '0;
    logic [W-1:0]  pin_out, pin_oe;
    logic          irq;

    int   tests = 0;
    int   fails = 0;
    bit   done  = 1'b0;
    item_t sb[$];

    always #2 clk = ~clk;

    gpio_port #(.WIDTH(W)) i_gpio_port (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_waddr(bus_waddr),
        .bus_wdata(bus_wdata), .bus_raddr(bus_raddr), .bus_rdata(bus_rdata),
        .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
    );

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [3:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_waddr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic expect_item(input kind_e k, input logic [3:0] a,
                               input logic [15:0] e, input string r);
        item_t it;
        it.kind = k; it.addr = a; it.exp = e; it.req = r;
        sb.push_back(it);
        wait (sb.size() == 0);
    endtask

    // monitor: pops expected items and compares against the ports
    initial begin
        forever begin
            @(negedge clk);
            if (sb.size() > 0) begin
                item_t it;
                logic [15:0] act;
                it = sb.pop_front();
                bus_raddr = it.addr;
                #1;
                case (it.kind)
                    K_REG:   act = bus_rdata;
                    K_IRQ:   act = {15'd0, irq};
                    K_OE:    act = pin_oe;
                    default: act = pin_out;
                endcase
                tests++;
                if (act !== it.exp) begin
                    fails++;
                    $display("FAIL %s kind=%0d addr=%0d actual=%h expected=%h",
                             it.req, it.kind, it.addr, act, it.exp);
                end
            end
        end
    end

    initial begin
        for (int i = 0; i < 20000; i++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            fails++;
            tests++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        cyc(3);
        rst_n = 1'b1;
        cyc(1);
        // R1 reset state
        expect_item(K_REG, 4'd0, 16'h0000, "R1 dir");
        expect_item(K_REG, 4'd1, 16'h0000, "R1 data");
        expect_item(K_REG, 4'd5, 16'h0000, "R1 mask");
        expect_item(K_REG, 4'd8, 16'h0000, "R1 pend");
        expect_item(K_OE,  4'd0, 16'h0000, "R1 oe");
        expect_item(K_IRQ, 4'd0, 16'h0000, "R1 irq");

        // R12 direct write
        wr(4'd1, 16'h00F0);
        expect_item(K_REG, 4'd1, 16'h00F0, "R12 data");
        expect_item(K_OUT, 4'd0, 16'h00F0, "R2 pin_out");

        // R2 direction
        wr(4'd0, 16'hFF00);
        expect_item(K_OE, 4'd0, 16'hFF00, "R2 oe");

        // R3 / R4 / R5 atomic updates
        wr(4'd2, 16'h0101);
        expect_item(K_REG, 4'd1, 16'h01F1, "R3 set");
        wr(4'd3, 16'h00F0);
        expect_item(K_REG, 4'd1, 16'h0101, "R4 clear");
        wr(4'd4, 16'h0003);
        expect_item(K_REG, 4'd1, 16'h0102, "R5 toggle");
        expect_item(K_OUT, 4'd0, 16'h0102, "R5 pin_out");

        // R6 synchronized input read
        @(negedge clk);
        pin_in = 16'h00A5;
        cyc(1);
        expect_item(K_REG, 4'd9, 16'h0100, "R6 after one edge");
        expect_item(K_REG, 4'd9, 16'h01A5, "R6 after two edges");

        // R7 / R10 level mode
        wr(4'd5, 16'h0001);
        expect_item(K_IRQ, 4'd0, 16'h0001, "R7 level high pin");
        wr(4'd5, 16'h0002);
        expect_item(K_IRQ, 4'd0, 16'h0000, "R7 level low pin");
        wr(4'd5, 16'h0000);
        expect_item(K_IRQ, 4'd0, 16'h0000, "R10 all masked");

        // R8 rising edge latch
        wr(4'd6, 16'h00FF);
        wr(4'd5, 16'h0002);
        expect_item(K_REG, 4'd8, 16'h0000, "R8 no pending yet");
        @(negedge clk);
        pin_in = 16'h00A7;
        cyc(3);
        expect_item(K_REG, 4'd8, 16'h0002, "R8 rise latched");
        expect_item(K_IRQ, 4'd0, 16'h0001, "R10 masked-in pending");
        @(negedge clk);
        pin_in = 16'h00A5;
        cyc(3);
        expect_item(K_REG, 4'd8, 16'h0002, "R9 fall ignored, latch held");
        wr(4'd8, 16'h0001);
        expect_item(K_REG, 4'd8, 16'h0002, "R8 zero bit no clear");
        wr(4'd8, 16'h0002);
        expect_item(K_REG, 4'd8, 16'h0000, "R8 cleared");
        expect_item(K_IRQ, 4'd0, 16'h0000, "R8 irq gone");

        // R9 both edges
        wr(4'd7, 16'h0002);
        @(negedge clk);
        pin_in = 16'h00A7;
        cyc(3);
        wr(4'd8, 16'h0002);
        expect_item(K_REG, 4'd8, 16'h0000, "R9 cleared before fall");
        @(negedge clk);
        pin_in = 16'h00A5;
        cyc(3);
        expect_item(K_REG, 4'd8, 16'h0002, "R9 fall latched");

        // R10 masked pin still records
        wr(4'd5, 16'h0000);
        expect_item(K_IRQ, 4'd0, 16'h0000, "R10 masked irq low");
        expect_item(K_REG, 4'd8, 16'h0002, "R10 pending kept");

        // R11 software interrupt on output pin 8
        wr(4'd3, 16'h0100);
        wr(4'd6, 16'h01FF);
        wr(4'd8, 16'hFFFF);
        wr(4'd5, 16'h0100);
        expect_item(K_IRQ, 4'd0, 16'h0000, "R11 idle");
        wr(4'd2, 16'h0100);
        cyc(1);
        expect_item(K_REG, 4'd8, 16'h0100, "R11 soft pending");
        expect_item(K_IRQ, 4'd0, 16'h0001, "R11 soft irq");

        cyc(2);
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule